// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is an SPI slave that sits in front of a 512-byte memory built from flip-flops. The host lowers chip select, shifts in an 8-bit command and then, depending on the command, an address byte and data bytes. The block answers on the serial output. The commands are: set and clear a write-enable flag, read and write a small status register, read memory sequentially, and write a page of 1 to 16 bytes.

All SPI pins are oversampled by a faster system clock through two-stage synchronizers, so the block lives in a single clock domain. SCK idles low (mode 0). Input bits are taken on SCK rising edges and output bits change on SCK falling edges. SCK may stall for any length of time. Writes to the memory array and to the protection field take effect when chip select rises. After that, a write-in-progress flag stays set for a fixed number of system clocks, during which only status reads are answered.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the status byte reads 0x00, and `so` is 0 whenever chip select is high.
- R2: Command 0x06 sets the write-enable flag (status bit 1). Command 0x04 clears it. Both act once the 8th command bit is taken.
- R3: Command 0000_A011 reads memory. Bit 3 of the command (A) is address bit 8, and the following byte gives address bits 7..0. All fields are MSB first. The data then appears on `so`, MSB first, one bit per SCK falling edge.
- R4: A read continues with consecutive addresses for as long as SCK runs. The address wraps from 511 to 0.
- R5: Command 0000_A010 plus an address byte starts a page write of 1 to 16 bytes. The low 4 address bits wrap inside the 16-byte page. The bytes are stored when chip select rises.
- R6: A memory write issued while the write-enable flag is clear changes nothing.
- R7: If chip select rises when the bits received are not a whole number of bytes, no memory or status write takes place, and the write-enable flag keeps its value.
- R8: A committed write clears the write-enable flag and sets write-in-progress (status bit 0) for `BUSY_CYCLES` system clocks. While that flag is set, every command except the status read (0x05) is ignored.
- R9: Command 0x01 followed by one byte loads status bits 3:2 (protect field) from bits 3:2 of that byte, only while write-enable is set. The status byte reads {0000, protect[1:0], write-enable, write-in-progress}.
- R10: With protect field 01, addresses 384..511 are protected. With 10, addresses 256..511 are protected. With 11, every address is protected. Bytes aimed at protected addresses are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, idles low |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block, 0 when idle |

## Verification
Single-byte writes followed by read-back are applied at both ends of each address half, so that a fault in the ninth address bit carried in the command shows up as data from the wrong half. A three-byte page write that starts two bytes before the end of its page separates in-page wrap from plain incrementing, and a read starting at 511 separates wrap to 0 from running off the end. Writes without the enable flag, writes aborted mid-byte, and commands sent while busy are each checked through the status byte and through memory read-back. Writes just inside and just outside each protect range tell the three protect encodings apart.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so
);
  // address width is fixed by the command format: one extra bit in the opcode
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int BW     = $clog2(BUSY_CYCLES + 1);

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  typedef enum logic [2:0] {S_OP, S_ADDR, S_WDAT, S_RDAT, S_RDSR, S_WRSR, S_SKIP} st_t;

  logic [2:0] cs_sy, sck_sy;
  logic [1:0] si_sy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy  <= '1;
      sck_sy <= '0;
      si_sy  <= '0;
    end else begin
      cs_sy  <= {cs_sy[1:0], cs_n};
      sck_sy <= {sck_sy[1:0], sck};
      si_sy  <= {si_sy[0], si};
    end

  wire cs_act = !cs_sy[1];
  wire cs_end = cs_sy[1] & !cs_sy[2];
  wire sck_r  = sck_sy[1] & !sck_sy[2];
  wire sck_f  = !sck_sy[1] & sck_sy[2];

  st_t               st;
  logic [2:0]        bit_cnt;
  logic [7:0]        sh, so_sh;
  logic              is_rd, a8, sending, wel, sr_have;
  logic [1:0]        bp, sr_new;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-PAGE_W-1:0] pg;
  logic [PAGE_W-1:0] widx;
  logic [PAGE-1:0]   wmask;
  logic [BW-1:0]     busy_cnt;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        wbuf [PAGE];

  wire [7:0]        rx_byte   = {sh[6:0], si_sy[1]};
  wire              byte_done = cs_act & sck_r & (bit_cnt == 3'd7);
  wire [ADDR_W-1:0] full_addr = {a8, rx_byte};
  wire              wip       = busy_cnt != '0;
  wire [7:0]        status    = {4'b0000, bp, wel, wip};

  wire commit_wr = cs_end && st == S_WDAT && bit_cnt == 3'd0 && |wmask && wel && !wip;
  wire commit_sr = cs_end && st == S_WRSR && bit_cnt == 3'd0 && sr_have && wel && !wip;
  wire commit    = commit_wr | commit_sr;

  function automatic logic locked(input logic [1:0] f, input logic [ADDR_W-1:0] a);
    case (f)
      2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
      2'b10:   return a[ADDR_W-1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_OP; bit_cnt <= '0; sh <= '0; so_sh <= '0; sending <= 1'b0;
      is_rd <= 1'b0; a8 <= 1'b0; rd_addr <= '0; pg <= '0; widx <= '0; wmask <= '0;
      wel <= 1'b0; bp <= '0; sr_new <= '0; sr_have <= 1'b0; busy_cnt <= '0;
    end else begin
      if (!cs_act) begin
        st <= S_OP; bit_cnt <= '0; sending <= 1'b0; so_sh <= '0;
      end else begin
        if (sck_r) begin
          bit_cnt <= bit_cnt + 3'd1;
          sh      <= rx_byte;
        end
        if (byte_done)
          case (st)
            S_OP:
              if (rx_byte == OP_RDSR) begin st <= S_RDSR; sending <= 1'b1; end
              else if (wip) st <= S_SKIP;
              else if (rx_byte == OP_WREN) begin wel <= 1'b1; st <= S_SKIP; end
              else if (rx_byte == OP_WRDI) begin wel <= 1'b0; st <= S_SKIP; end
              else if (rx_byte == OP_WRSR) begin st <= S_WRSR; sr_have <= 1'b0; end
              else if (rx_byte[7:4] == 4'h0 && rx_byte[2:1] == 2'b01) begin
                a8 <= rx_byte[3]; is_rd <= rx_byte[0]; st <= S_ADDR;
              end else st <= S_SKIP;
            S_ADDR: begin
              rd_addr <= full_addr;
              pg      <= full_addr[ADDR_W-1:PAGE_W];
              widx    <= full_addr[PAGE_W-1:0];
              wmask   <= '0;
              sending <= is_rd;
              st      <= is_rd ? S_RDAT : S_WDAT;
            end
            S_WDAT: begin
              wmask[widx] <= 1'b1;
              widx        <= widx + PAGE_W'(1);
            end
            S_WRSR:
              if (!sr_have) begin sr_new <= rx_byte[3:2]; sr_have <= 1'b1; end
            default: ;
          endcase
        if (sck_f && sending) begin
          if (bit_cnt == 3'd0) begin
            so_sh <= (st == S_RDSR) ? status : mem[rd_addr];
            if (st == S_RDAT) rd_addr <= rd_addr + ADDR_W'(1);
          end else so_sh <= {so_sh[6:0], 1'b0};
        end
      end
      if (commit) begin
        wel      <= 1'b0;
        busy_cnt <= BW'(BUSY_CYCLES);
      end else if (wip) busy_cnt <= busy_cnt - BW'(1);
      if (commit_sr) bp <= sr_new;
    end

  always_ff @(posedge clk) begin
    if (byte_done && st == S_WDAT) wbuf[widx] <= rx_byte;
    for (int i = 0; i < PAGE; i++)
      if (commit_wr && wmask[i] && !locked(bp, {pg, PAGE_W'(i)}))
        mem[{pg, PAGE_W'(i)}] <= wbuf[i];
  end

  assign so = sending ? so_sh[7] : 1'b0;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n) !cs_act |=> !so);
  p_wel_rise_r2:   assert property (@(posedge clk) disable iff (!rst_n) $rose(wel) |-> !wip);
  p_abort_r7:      assert property (@(posedge clk) disable iff (!rst_n)
                     (cs_end && bit_cnt != 3'd0) |=> (!wip || $past(wip)));
  p_commit_r8:     assert property (@(posedge clk) disable iff (!rst_n) commit |=> (wip && !wel));
  p_bp_gate_r9:    assert property (@(posedge clk) disable iff (!rst_n)
                     !$stable(bp) |-> ($past(wel) && !$past(wip)));
endmodule

// File: tb/spi_eeprom_slave_bench.sv
module spi_eeprom_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int BUSY = 600;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  spi_eeprom_slave #(.PAGE_W(4), .BUSY_CYCLES(BUSY)) u_spi_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {address[8:0], data[7:0]}
  localparam logic [16:0] VEC [7] = '{
    {9'h000, 8'h3C}, {9'h1FF, 8'hC3}, {9'h100, 8'h5A}, {9'h0FF, 8'hA5},
    {9'h180, 8'h77}, {9'h020, 8'h81}, {9'h17F, 8'h42}};

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      si = tx[b]; tick(HALF); rx[b] = so; sck = 1'b1; tick(HALF); sck = 1'b0;
    end
  endtask

  task automatic sel();   cs_n = 1'b0; tick(HALF); endtask
  task automatic desel(); tick(HALF); cs_n = 1'b1; tick(2*HALF); endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (!s[0]) return;
    end
  endtask

  task automatic wr(input logic [8:0] a, input int n, input logic [7:0] d0, d1, d2);
    logic [7:0] d;
    sel();
    xfer({4'h0, a[8], 3'b010}, d);
    xfer(a[7:0], d);
    xfer(d0, d);
    if (n > 1) xfer(d1, d);
    if (n > 2) xfer(d2, d);
    desel();
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] r0, output logic [7:0] r1);
    logic [7:0] d;
    sel();
    xfer({4'h0, a[8], 3'b011}, d);
    xfer(a[7:0], d);
    xfer(8'h00, r0);
    xfer(8'h00, r1);
    desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    sel(); xfer(8'h01, d); xfer(v, d); desel();
  endtask

  logic [7:0] s, r0, r1;

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    checks++; if (so !== 1'b0) begin fails++; $display("FAIL R1 idle so: got %b expected 0", so); end
    rdsr(s); chk("R1 status after reset", s, 8'h00);

    cmd(8'h06); rdsr(s); chk("R2 set enable", s, 8'h02);
    cmd(8'h04); rdsr(s); chk("R2 clear enable", s, 8'h00);

    for (int v = 0; v < 7; v++) begin
      cmd(8'h06);
      wr(VEC[v][16:8], 1, VEC[v][7:0], 8'h00, 8'h00);
      rdsr(s); chk("R8 busy after write", s, 8'h01);
      wait_ready();
      rd(VEC[v][16:8], r0, r1); chk("R3 R5 read back", r0, VEC[v][7:0]);
    end

    wr(9'h020, 1, 8'hEE, 8'h00, 8'h00);
    rdsr(s); chk("R6 no commit without enable", s, 8'h00);
    rd(9'h020, r0, r1); chk("R6 data unchanged", r0, 8'h81);

    cmd(8'h06); wr(9'h10E, 3, 8'h11, 8'h22, 8'h33); wait_ready();
    rd(9'h10E, r0, r1); chk("R5 page byte 0", r0, 8'h11); chk("R5 page byte 1", r1, 8'h22);
    rd(9'h100, r0, r1); chk("R5 page wrap", r0, 8'h33);

    rd(9'h1FF, r0, r1); chk("R4 read at 511", r0, 8'hC3); chk("R4 wrap to 0", r1, 8'h3C);
    rd(9'h17F, r0, r1); chk("R4 sequential next", r1, 8'h77);

    cmd(8'h06);
    sel(); xfer(8'h02, r0); xfer(8'h20, r0); xfer(8'h99, r0);
    for (int b = 0; b < 3; b++) begin
      si = 1'b1; tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
    end
    desel();
    rdsr(s); chk("R7 abort keeps enable, no busy", s, 8'h02);
    rd(9'h020, r0, r1); chk("R7 data unchanged", r0, 8'h81);
    cmd(8'h04);

    cmd(8'h06); wr(9'h030, 1, 8'h5C, 8'h00, 8'h00);
    cmd(8'h06); rdsr(s); chk("R8 enable ignored while busy", s, 8'h01);
    wait_ready(); rdsr(s); chk("R8 busy ends", s, 8'h00);

    wrsr(8'h04); wait_ready(); rdsr(s); chk("R9 no status write without enable", s, 8'h00);
    cmd(8'h06); wrsr(8'h04); wait_ready(); rdsr(s); chk("R9 protect 01", s, 8'h04);
    cmd(8'h06); wr(9'h180, 1, 8'h99, 8'h00, 8'h00); wait_ready();
    rd(9'h180, r0, r1); chk("R10 01 protects 384", r0, 8'h77);
    cmd(8'h06); wr(9'h17F, 1, 8'h24, 8'h00, 8'h00); wait_ready();
    rd(9'h17F, r0, r1); chk("R10 01 allows 383", r0, 8'h24);

    cmd(8'h06); wrsr(8'h08); wait_ready(); rdsr(s); chk("R9 protect 10", s, 8'h08);
    cmd(8'h06); wr(9'h100, 1, 8'h99, 8'h00, 8'h00); wait_ready();
    rd(9'h100, r0, r1); chk("R10 10 protects 256", r0, 8'h33);
    cmd(8'h06); wr(9'h0FF, 1, 8'h66, 8'h00, 8'h00); wait_ready();
    rd(9'h0FF, r0, r1); chk("R10 10 allows 255", r0, 8'h66);

    cmd(8'h06); wrsr(8'h0C); wait_ready();
    cmd(8'h06); wr(9'h000, 1, 8'h99, 8'h00, 8'h00); wait_ready();
    rd(9'h000, r0, r1); chk("R10 11 protects 0", r0, 8'h3C);
    wrsr(8'h00); wait_ready(); rdsr(s); chk("R9 field kept", s, 8'h0C);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule